// File: doc/BRIEF.md
# Per-Core Constant Countdown Timer

This block is a countdown timer for one processor core. It runs off its own constant 100 MHz timer clock, one tick per cycle, so its rate does not depend on how fast the core runs. Software drives it through a single 64-bit configuration word. Bit 0 of that word arms the timer. Bit 1 chooses between repeating and single-shot behaviour. Bits 47:2 give the tick count, and the two control bits are masked out of it. Writing the word with the arm bit set loads the countdown and starts it. Writing it with the arm bit clear freezes the countdown where it stands.

When the countdown steps from 1 to 0, the block latches an interrupt request onto one fixed line of the core's interrupt vector. In repeating mode the countdown then reloads from the stored count and keeps going. In single-shot mode the block clears the arm bit inside the stored configuration word and parks the countdown at 0. A read port returns one of three values: the stored configuration, the ticks left before expiry, or a free-running 64-bit tick counter that starts at 0 on reset.

Top module: `ctimer_top`

## Requirements
- R1: While reset is held, the stored configuration, the remaining count and the free-running counter all read 0, and every interrupt line is low.
- R2: A write stores all 64 bits of the written word, and read select 0 returns them unchanged.
- R3: A write with bit 0 set loads the remaining count with the written word masked to bits 47:2. The count is then lowered by one on every following clock.
- R4: When the remaining count steps from 1 to 0, the interrupt rises at that same clock edge. This is exactly N clocks after the write edge, where N is the masked count.
- R5: With bit 1 set, each expiry reloads the masked count from the stored configuration, so the interrupt recurs every N clocks and the configuration is left unchanged.
- R6: With bit 1 clear, an expiry clears bit 0 of the stored configuration and keeps every other bit. The remaining count reads 0 and no further expiry follows.
- R7: A write with bit 0 clear freezes the remaining count at its value in the write cycle, and no expiry follows.
- R8: The interrupt drives only line 11 of a 13-line vector, and every other line stays 0. The line stays high until the clear input is sampled high. An expiry in the same cycle as a clear keeps the line high.
- R9: A configuration write in the cycle where the count would step from 1 to 0 wins. No interrupt is raised, and the new value is loaded instead of the reload.
- R10: The free-running counter rises by exactly one on every clock after reset and wraps modulo 2^64.
- R11: Read select encoding: 0 returns the configuration, 1 the remaining count, 2 the free-running counter, and 3 returns 0.
- R12: An armed write whose masked count is 0 leaves the remaining count at 0 and never raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Constant 100 MHz timer clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 64 | Configuration word to write |
| rd_sel | input | 2 | Read select (0 config, 1 remaining, 2 free-running, 3 zero) |
| rd_data | output | 64 | Selected read value |
| irq_clr | input | 1 | Clears the latched timer interrupt |
| irq_vec | output | 13 | Core interrupt vector; only line 11 is driven |

## Verification
The bound checker checks these on every cycle: an armed write loads the masked count, each expiry raises line 11, a single-shot expiry drops the arm bit and zeroes the count, and a repeating expiry reloads from the stored word. It also checks that a disarmed timer holds its count, that the latched line survives until a clear, that a write blocks the interrupt in the collision cycle, and that the free-running counter steps by one. Some behaviour only the directed scenarios can show: the exact clock on which the interrupt first appears after a write, the interval between repeated expiries, set-over-clear when an expiry meets a clear, the frozen value after a stop, and the zero-count case.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;
  localparam int CFG_W         = 64;
  localparam int DEF_EN_BIT    = 0;
  localparam int DEF_PER_BIT   = 1;
  localparam int DEF_CNT_LSB   = 2;
  localparam int DEF_CNT_MSB   = 47;
  localparam int DEF_IRQ_N     = 13;
  localparam int DEF_IRQ_LINE  = 11;

  typedef logic [CFG_W-1:0] cfg_word_t;

  typedef enum logic [1:0] {
    RD_CFG    = 2'd0,
    RD_REMAIN = 2'd1,
    RD_STABLE = 2'd2,
    RD_NONE   = 2'd3
  } rd_sel_e;

  // keep only bits lsb..msb of a configuration word
  function automatic cfg_word_t cnt_field(input cfg_word_t w, input int lsb, input int msb);
    cfg_word_t r;
    r = '0;
    for (int i = 0; i < CFG_W; i++) begin
      if (i >= lsb && i <= msb) r[i] = w[i];
    end
    return r;
  endfunction

  // stored word after a single-shot expiry: arm bit dropped
  function automatic cfg_word_t disarm(input cfg_word_t w, input int en_bit);
    cfg_word_t r;
    r = w;
    r[en_bit] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/ctimer_cfg_reg.sv
module ctimer_cfg_reg
  import ctimer_pkg::*;
#(
  parameter int EN_BIT  = DEF_EN_BIT,
  parameter int PER_BIT = DEF_PER_BIT
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  cfg_word_t wr_data,
  input  logic      expire,
  output cfg_word_t cfg_q
);
  cfg_word_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en)                          cfg_d = wr_data;
    else if (expire && !cfg_q[PER_BIT]) cfg_d = disarm(cfg_q, EN_BIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/ctimer_countdown.sv
module ctimer_countdown
  import ctimer_pkg::*;
#(
  parameter int EN_BIT  = DEF_EN_BIT,
  parameter int PER_BIT = DEF_PER_BIT,
  parameter int CNT_LSB = DEF_CNT_LSB,
  parameter int CNT_MSB = DEF_CNT_MSB
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  cfg_word_t wr_data,
  input  cfg_word_t cfg_q,
  output cfg_word_t remain,
  output logic      expire
);
  cfg_word_t load_val, reload_val, remain_d;
  logic      run;

  assign run        = cfg_q[EN_BIT];
  assign load_val   = cnt_field(wr_data, CNT_LSB, CNT_MSB);
  assign reload_val = cnt_field(cfg_q, CNT_LSB, CNT_MSB);
  // a write in the same cycle suppresses the expiry
  assign expire     = run && !wr_en && (remain == cfg_word_t'(1));

  always_comb begin
    remain_d = remain;
    if (wr_en) begin
      if (wr_data[EN_BIT]) remain_d = load_val;
    end else if (expire) begin
      remain_d = cfg_q[PER_BIT] ? reload_val : '0;
    end else if (run && remain != '0) begin
      remain_d = remain - cfg_word_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain <= '0;
    else        remain <= remain_d;
  end
endmodule

// File: rtl/ctimer_stable.sv
module ctimer_stable
  import ctimer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  output cfg_word_t stable
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stable <= '0;
    else        stable <= stable + cfg_word_t'(1);
  end
endmodule

// File: rtl/ctimer_irq.sv
module ctimer_irq #(
  parameter int IRQ_N    = 13,
  parameter int IRQ_LINE = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic             clr,
  output logic [IRQ_N-1:0] irq_vec
);
  for (genvar i = 0; i < IRQ_N; i++) begin : g_line
    if (i == IRQ_LINE) begin : g_timer
      logic pend;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pend <= 1'b0;
        else if (set) pend <= 1'b1;
        else if (clr) pend <= 1'b0;
      end
      assign irq_vec[i] = pend;
    end else begin : g_idle
      assign irq_vec[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ctimer_top.sv
module ctimer_top
  import ctimer_pkg::*;
#(
  parameter int EN_BIT   = DEF_EN_BIT,
  parameter int PER_BIT  = DEF_PER_BIT,
  parameter int CNT_LSB  = DEF_CNT_LSB,
  parameter int CNT_MSB  = DEF_CNT_MSB,
  parameter int IRQ_N    = DEF_IRQ_N,
  parameter int IRQ_LINE = DEF_IRQ_LINE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [63:0]      cfg_wr_data,
  input  logic [1:0]       rd_sel,
  output logic [63:0]      rd_data,
  input  logic             irq_clr,
  output logic [IRQ_N-1:0] irq_vec
);
  cfg_word_t cfg_q, remain, stable;
  logic      expire;

  ctimer_cfg_reg #(.EN_BIT(EN_BIT), .PER_BIT(PER_BIT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .expire(expire), .cfg_q(cfg_q)
  );

  ctimer_countdown #(.EN_BIT(EN_BIT), .PER_BIT(PER_BIT),
                     .CNT_LSB(CNT_LSB), .CNT_MSB(CNT_MSB)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .cfg_q(cfg_q), .remain(remain), .expire(expire)
  );

  ctimer_stable u_stable (.clk(clk), .rst_n(rst_n), .stable(stable));

  ctimer_irq #(.IRQ_N(IRQ_N), .IRQ_LINE(IRQ_LINE)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(expire), .clr(irq_clr), .irq_vec(irq_vec)
  );

  always_comb begin
    case (rd_sel_e'(rd_sel))
      RD_CFG:    rd_data = cfg_q;
      RD_REMAIN: rd_data = remain;
      RD_STABLE: rd_data = stable;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ctimer_chk.sv
module ctimer_chk
  import ctimer_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_wr_en,
  input cfg_word_t            cfg_wr_data,
  input logic                 irq_clr,
  input logic [DEF_IRQ_N-1:0] irq_vec,
  input cfg_word_t            cfg_q,
  input cfg_word_t            remain,
  input cfg_word_t            stable,
  input logic                 expire
);
  localparam logic [DEF_IRQ_N-1:0] LINE_MASK = DEF_IRQ_N'(1) << DEF_IRQ_LINE;

  logic line;
  assign line = irq_vec[DEF_IRQ_LINE];

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en && cfg_wr_data[DEF_EN_BIT] |=>
      remain == cnt_field($past(cfg_wr_data), DEF_CNT_LSB, DEF_CNT_MSB));

  // R4
  expire_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> line);

  // R5
  periodic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire && cfg_q[DEF_PER_BIT] |=>
      remain == cnt_field(cfg_q, DEF_CNT_LSB, DEF_CNT_MSB) && $stable(cfg_q));

  // R6
  oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !cfg_q[DEF_PER_BIT] |=> !cfg_q[DEF_EN_BIT] && remain == '0);

  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[DEF_EN_BIT] || cfg_wr_en) && !(cfg_wr_en && cfg_wr_data[DEF_EN_BIT])
      |=> $stable(remain));

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line && !irq_clr |=> line);

  // R8
  other_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec & ~LINE_MASK) == '0);

  // R9
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en && cfg_q[DEF_EN_BIT] && remain == cfg_word_t'(1) && !line |=> !line);

  // R10
  stable_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stable == $past(stable) + cfg_word_t'(1));
endmodule

bind ctimer_top ctimer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
  .irq_clr(irq_clr), .irq_vec(irq_vec), .cfg_q(cfg_q), .remain(remain),
  .stable(stable), .expire(expire)
);

// File: tb/tb_ctimer_top.sv
module tb_ctimer_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [63:0] cfg_wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [63:0] rd_data;
  logic        irq_clr = 1'b0;
  logic [12:0] irq_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ctimer_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_clr(irq_clr), .irq_vec(irq_vec)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [63:0] v);
    rd_sel = s;
    #1;
    v = rd_data;
  endtask

  task automatic chk_rd(input string req, input logic [1:0] s, input logic [63:0] exp);
    logic [63:0] v;
    rd(s, v);
    check(req, v, exp);
  endtask

  task automatic chk_irq(input string req, input logic exp);
    check(req, {51'd0, irq_vec}, exp ? 64'h800 : 64'h0);
  endtask

  task automatic write_cfg(input logic [63:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk_rd("R1 cfg", 2'd0, 64'h0);
    chk_rd("R1 remain", 2'd1, 64'h0);
    chk_rd("R1 stable", 2'd2, 64'h0);
    chk_irq("R1 irq", 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_stable();
    logic [63:0] a, b;
    rd(2'd2, a);
    repeat (37) @(negedge clk);
    rd(2'd2, b);
    check("R10 stable delta", b - a, 64'd37);
  endtask

  task automatic t_oneshot();
    write_cfg(64'hABC0_0000_0000_0009);
    chk_rd("R2 cfg readback", 2'd0, 64'hABC0_0000_0000_0009);
    chk_rd("R3 masked load", 2'd1, 64'd8);
    @(negedge clk);
    chk_rd("R3 decrement", 2'd1, 64'd7);
    repeat (6) @(negedge clk);
    chk_rd("R4 remain one", 2'd1, 64'd1);
    chk_irq("R4 no early irq", 1'b0);
    @(negedge clk);
    chk_irq("R4 irq at N", 1'b1);
    chk_rd("R6 en cleared", 2'd0, 64'hABC0_0000_0000_0008);
    chk_rd("R6 remain zero", 2'd1, 64'd0);
    pulse_clr();
    chk_irq("R8 cleared", 1'b0);
    repeat (20) @(negedge clk);
    chk_irq("R6 no re-expiry", 1'b0);
  endtask

  task automatic t_periodic();
    write_cfg(64'hB);
    repeat (8) @(negedge clk);
    chk_irq("R5 first expiry", 1'b1);
    chk_rd("R5 reload", 2'd1, 64'd8);
    pulse_clr();
    chk_irq("R5 cleared", 1'b0);
    repeat (6) @(negedge clk);
    chk_irq("R5 not yet", 1'b0);
    @(negedge clk);
    chk_irq("R5 second expiry", 1'b1);
    chk_rd("R5 cfg kept", 2'd0, 64'hB);
    write_cfg(64'h0);
    pulse_clr();
  endtask

  task automatic t_sticky();
    write_cfg(64'h7);
    repeat (4) @(negedge clk);
    chk_irq("R8 raised", 1'b1);
    repeat (3) @(negedge clk);
    chk_irq("R8 held without clear", 1'b1);
    irq_clr = 1'b1;
    @(negedge clk);
    chk_irq("R8 set beats clear", 1'b1);
    @(negedge clk);
    irq_clr = 1'b0;
    chk_irq("R8 clear takes effect", 1'b0);
    write_cfg(64'h0);
    pulse_clr();
  endtask

  task automatic t_stop();
    write_cfg(64'h41);
    chk_rd("R3 load 64", 2'd1, 64'd64);
    repeat (10) @(negedge clk);
    write_cfg(64'h40);
    chk_rd("R7 frozen", 2'd1, 64'd53);
    chk_rd("R7 cfg", 2'd0, 64'h40);
    repeat (100) @(negedge clk);
    chk_rd("R7 still frozen", 2'd1, 64'd53);
    chk_irq("R7 no expiry", 1'b0);
  endtask

  task automatic t_collide();
    write_cfg(64'h9);
    repeat (7) @(negedge clk);
    chk_rd("R9 at one", 2'd1, 64'd1);
    cfg_wr_en = 1'b1;
    cfg_wr_data = 64'h11;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    chk_irq("R9 no irq", 1'b0);
    chk_rd("R9 new load", 2'd1, 64'd16);
    chk_rd("R9 new cfg", 2'd0, 64'h11);
    write_cfg(64'h0);
    pulse_clr();
  endtask

  task automatic t_zero();
    write_cfg(64'h1);
    repeat (20) @(negedge clk);
    chk_rd("R12 remain zero", 2'd1, 64'd0);
    chk_irq("R12 no irq", 1'b0);
    chk_rd("R12 cfg kept", 2'd0, 64'h1);
    chk_rd("R11 select 3", 2'd3, 64'h0);
  endtask

  initial begin
    t_reset();
    t_stable();
    t_oneshot();
    t_periodic();
    t_sticky();
    t_stop();
    t_collide();
    t_zero();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule